// File: doc/BRIEF.md
# Multi-Block Erase Scheduler with Suspend

This block sequences the erasure of a 1 MiB byte-addressed non-volatile array that is split into 19 blocks of unequal size. It receives already-decoded requests (start a block erase, add another block, erase the whole chip, suspend, resume, abort) and turns them into a series of handshakes with the array. For each block it runs a pre-program handshake, which writes all bytes to 00h, and then an erase handshake, which brings the block to FFh. A block erase does not start at once. It first collects further blocks during an entry window that restarts on every added block. A suspend stops the sequence at a safe point within a bounded number of cycles. A resume picks up the blocks that remain.

The blocks are numbered by ascending base address, so bit i of every block mask is the block with the i-th lowest base. The parameter `TOP_BOOT` selects one of two layouts. In the top-boot layout the small blocks sit at the top of the address space. In the bottom-boot layout they sit at the bottom. Command decoding and status byte formatting happen elsewhere. The block reports whether it is busy, whether the entry window is open, whether it is suspended, whether the array reported a failure, and which blocks remain selected.

Top module: `erase_sched`

## Requirements
- R1: The block number is derived from `blkAddr[19:0]`. With TOP_BOOT=1: addresses below F0000h give addr[19:16] (blocks 0 to 14, 64K each); F0000h–F7FFFh gives 15; F8000h–F9FFFh gives 16; FA000h–FBFFFh gives 17; FC000h–FFFFFh gives 18. With TOP_BOOT=0: 00000h–03FFFh gives 0; 04000h–05FFFh gives 1; 06000h–07FFFh gives 2; 08000h–0FFFFh gives 3; at or above 10000h the number is addr[19:16]+3. Bit n of `eraseMask` stands for block n.
- R2: In idle, `blkEraseReq` replaces the mask with the addressed block and opens the window. `windowOpen` then stays high for WIN_CYC cycles after the request edge. While the window is open, `blkEraseReq` or `addBlkReq` ORs its block into the mask and restarts the full count. The pre-program phase starts in the cycle after the window closes.
- R3: Blocks are processed in ascending block number, and `opBlk` shows the block in work. For each block, `preReq` is held until a `preAck` arrives, and then `ersReq` is held until an `ersAck` arrives. An ack is taken only in a cycle in which its request is high. `preReq` and `ersReq` are never high together.
- R4: In idle, `chipEraseReq` sets all 19 mask bits and raises `preReq` on block 0 in the next cycle, with no window.
- R5: A `suspendReq` during a non-chip pre-program or erase phase makes `suspended` rise no later than SUSP_LAT cycles after the request edge, or at an earlier ack. While suspended, both requests and `busy` are low. A block interrupted before its erase ack restarts with pre-program on resume.
- R6: A `suspendReq` while the window is open closes the window and enters the suspended state at once.
- R7: `suspendReq` has no effect in idle, during a chip erase, or after a fault.
- R8: `resumeReq` while suspended raises `preReq` in the next cycle on the lowest block still selected.
- R9: `abortReq` in any non-idle state returns to idle in the next cycle. The bits of blocks not yet erased stay set in `eraseMask` as invalid markers until the next erase request.
- R10: An ack taken with `ackFail` high raises `errFlag` and stops the sequence: no requests, `busy` low, and new requests ignored, until `abortReq` or reset clears it.
- R11: After reset all outputs are low and the mask is empty.
- R12: Each successful erase ack clears that block's mask bit. After the last ack, `busy` drops and the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkEraseReq | input | 1 | Block erase confirm for the block at blkAddr |
| addBlkReq | input | 1 | Additional block confirm while the window is open |
| chipEraseReq | input | 1 | Erase all blocks |
| suspendReq | input | 1 | Suspend request |
| resumeReq | input | 1 | Resume request |
| abortReq | input | 1 | Read/reset abort |
| blkAddr | input | 20 | Byte address selecting the block |
| preAck | input | 1 | Array done with pre-program |
| ersAck | input | 1 | Array done with erase |
| ackFail | input | 1 | Qualifies the ack in the same cycle as failed |
| preReq | output | 1 | Pre-program request for opBlk |
| ersReq | output | 1 | Erase request for opBlk |
| opBlk | output | 5 | Block number being worked on |
| busy | output | 1 | Window open or erasing |
| windowOpen | output | 1 | Entry window running |
| eraseMask | output | 19 | Blocks selected and not yet erased |
| suspended | output | 1 | Sequence suspended |
| errFlag | output | 1 | Array reported a failure |

## Verification
The hardest case to reach is a suspend that arrives while a handshake is still open. Only then does the latency bound, rather than an ack, decide when `suspended` rises. Only then is the interrupted block later redone from pre-program. The bench models the array as a responder that can be switched off, so it can hold the design in the pre-program phase. It can then place a suspend at a known edge and sample the exact cycle in which the request drops. A second layout instance shares the stimulus, so that the address table drives both layouts at once.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;
  localparam int ADDR_W  = 20;
  localparam int NUM_BLK = 19;
  localparam int IDX_W   = $clog2(NUM_BLK);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WINDOW, ST_PRE, ST_ERS, ST_SUSP, ST_FAULT
  } schedState_t;

  typedef struct packed {
    logic loadOne;
    logic addOne;
    logic loadAll;
    logic clearCur;
    logic startWin;
    logic startLat;
  } schedStrobe_t;

  function automatic logic [IDX_W-1:0] blkIndex(input logic [ADDR_W-1:0] a, input bit topBoot);
    logic [3:0] hi;
    hi = a[ADDR_W-1 -: 4];
    if (topBoot) begin
      if (hi != 4'hF)  return IDX_W'(hi);
      else if (!a[15]) return IDX_W'(15);
      else if (a[14])  return IDX_W'(18);
      else if (a[13])  return IDX_W'(17);
      else             return IDX_W'(16);
    end else begin
      if (hi != 4'h0)  return IDX_W'(hi) + IDX_W'(3);
      else if (a[15])  return IDX_W'(3);
      else if (!a[14]) return IDX_W'(0);
      else if (a[13])  return IDX_W'(2);
      else             return IDX_W'(1);
    end
  endfunction
endpackage

// File: rtl/erase_sched_dp.sv
module erase_sched_dp
  import erase_sched_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1,
  parameter int WIN_CYC  = 16,
  parameter int SUSP_LAT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  schedStrobe_t        stb,
  input  logic [ADDR_W-1:0]   blkAddr,
  output logic [NUM_BLK-1:0]  eraseMask,
  output logic [IDX_W-1:0]    curIdx,
  output logic                winDone,
  output logic                latDone,
  output logic                lastBlk
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int LAT_W = $clog2(SUSP_LAT + 1);

  logic [IDX_W-1:0]   reqIdx;
  logic [NUM_BLK-1:0] reqBit, curBit;
  logic [WIN_W-1:0]   winCnt;
  logic [LAT_W-1:0]   latCnt;

  assign reqIdx = blkIndex(blkAddr, TOP_BOOT);
  assign reqBit = NUM_BLK'(1) << reqIdx;
  assign curBit = NUM_BLK'(1) << curIdx;

  always_comb begin
    curIdx = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--)
      if (eraseMask[i]) curIdx = IDX_W'(i);
  end

  assign lastBlk = (eraseMask & ~curBit) == '0;
  assign winDone = winCnt == '0;
  assign latDone = latCnt == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseMask <= '0;
    end else if (stb.loadAll) begin
      eraseMask <= '1;
    end else if (stb.loadOne) begin
      eraseMask <= reqBit;
    end else if (stb.addOne) begin
      eraseMask <= eraseMask | reqBit;
    end else if (stb.clearCur) begin
      eraseMask <= eraseMask & ~curBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             winCnt <= '0;
    else if (stb.startWin) winCnt <= WIN_W'(WIN_CYC - 1);
    else if (!winDone)     winCnt <= winCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latCnt <= '0;
    else if (stb.startLat) latCnt <= LAT_W'(SUSP_LAT - 1);
    else if (!latDone)     latCnt <= latCnt - 1'b1;
  end
endmodule

// File: rtl/erase_sched_ctrl.sv
module erase_sched_ctrl
  import erase_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         blkEraseReq,
  input  logic         addBlkReq,
  input  logic         chipEraseReq,
  input  logic         suspendReq,
  input  logic         resumeReq,
  input  logic         abortReq,
  input  logic         preAck,
  input  logic         ersAck,
  input  logic         ackFail,
  input  logic         winDone,
  input  logic         latDone,
  input  logic         lastBlk,
  output schedStrobe_t stb,
  output logic         preReq,
  output logic         ersReq,
  output logic         busy,
  output logic         windowOpen,
  output logic         suspended,
  output logic         errFlag
);
  schedState_t state, nxt;
  logic chipMode, nChip, suspPend, nPend, ack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      chipMode <= 1'b0;
      suspPend <= 1'b0;
    end else begin
      state    <= nxt;
      chipMode <= nChip;
      suspPend <= nPend;
    end
  end

  assign ack = (state == ST_PRE) ? preAck : ersAck;

  always_comb begin
    nxt   = state;
    stb   = '0;
    nChip = chipMode;
    nPend = suspPend;
    if (abortReq && state != ST_IDLE) begin
      nxt   = ST_IDLE;
      nPend = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (chipEraseReq) begin
            stb.loadAll = 1'b1;
            nChip       = 1'b1;
            nxt         = ST_PRE;
          end else if (blkEraseReq) begin
            stb.loadOne  = 1'b1;
            stb.startWin = 1'b1;
            nChip        = 1'b0;
            nxt          = ST_WINDOW;
          end
        end
        ST_WINDOW: begin
          if (suspendReq) begin
            nxt = ST_SUSP;
          end else if (blkEraseReq || addBlkReq) begin
            stb.addOne   = 1'b1;
            stb.startWin = 1'b1;
          end else if (winDone) begin
            nxt = ST_PRE;
          end
        end
        ST_PRE, ST_ERS: begin
          if (ack && ackFail) begin
            nxt = ST_FAULT;
          end else if (ack) begin
            if (state == ST_ERS) begin
              stb.clearCur = 1'b1;
              if (lastBlk)       nxt = ST_IDLE;
              else if (suspPend) nxt = ST_SUSP;
              else               nxt = ST_PRE;
            end else begin
              nxt = suspPend ? ST_SUSP : ST_ERS;
            end
          end else if (suspPend && latDone) begin
            nxt = ST_SUSP;
          end
          if (nxt == ST_SUSP || nxt == ST_IDLE || nxt == ST_FAULT) begin
            nPend = 1'b0;
          end else if (suspendReq && !chipMode && !suspPend) begin
            nPend        = 1'b1;
            stb.startLat = 1'b1;
          end
        end
        ST_SUSP: if (resumeReq) nxt = ST_PRE;
        ST_FAULT: nxt = ST_FAULT;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign preReq     = state == ST_PRE;
  assign ersReq     = state == ST_ERS;
  assign windowOpen = state == ST_WINDOW;
  assign busy       = state inside {ST_WINDOW, ST_PRE, ST_ERS};
  assign suspended  = state == ST_SUSP;
  assign errFlag    = state == ST_FAULT;
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import erase_sched_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1,
  parameter int WIN_CYC  = 16,
  parameter int SUSP_LAT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               blkEraseReq,
  input  logic               addBlkReq,
  input  logic               chipEraseReq,
  input  logic               suspendReq,
  input  logic               resumeReq,
  input  logic               abortReq,
  input  logic [19:0]        blkAddr,
  input  logic               preAck,
  input  logic               ersAck,
  input  logic               ackFail,
  output logic               preReq,
  output logic               ersReq,
  output logic [4:0]         opBlk,
  output logic               busy,
  output logic               windowOpen,
  output logic [18:0]        eraseMask,
  output logic               suspended,
  output logic               errFlag
);
  schedStrobe_t stb;
  logic winDone, latDone, lastBlk;

  erase_sched_ctrl i_ctrl (
    .clk, .rstN, .blkEraseReq, .addBlkReq, .chipEraseReq, .suspendReq,
    .resumeReq, .abortReq, .preAck, .ersAck, .ackFail,
    .winDone, .latDone, .lastBlk, .stb,
    .preReq, .ersReq, .busy, .windowOpen, .suspended, .errFlag
  );

  erase_sched_dp #(.TOP_BOOT(TOP_BOOT), .WIN_CYC(WIN_CYC), .SUSP_LAT(SUSP_LAT)) i_dp (
    .clk, .rstN, .stb, .blkAddr, .eraseMask, .curIdx(opBlk),
    .winDone, .latDone, .lastBlk
  );
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk (
  input logic        clk,
  input logic        rstN,
  input logic        suspendReq,
  input logic        abortReq,
  input logic        preAck,
  input logic        ersAck,
  input logic        ackFail,
  input logic        preReq,
  input logic        ersReq,
  input logic        busy,
  input logic        windowOpen,
  input logic [18:0] eraseMask,
  input logic        suspended,
  input logic        errFlag
);
  // R3: one array request at a time
  a_r3_one_req: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({preReq, ersReq}));

  // R2: an open window counts as busy
  a_r2_window_busy: assert property (@(posedge clk) disable iff (!rstN)
    windowOpen |-> busy && !preReq && !ersReq);

  // R5: suspended means no activity
  a_r5_susp_quiet: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !busy && !preReq && !ersReq && !errFlag);

  // R10: a failed ack latches the error
  a_r10_fail_latches: assert property (@(posedge clk) disable iff (!rstN)
    ((preReq && preAck) || (ersReq && ersAck)) && ackFail && !abortReq |=> errFlag);

  // R12: a good erase ack removes exactly one block
  a_r12_mask_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    ersReq && ersAck && !ackFail && !abortReq |=>
      $countones(eraseMask) + 1 == $countones($past(eraseMask)));

  // R7: suspend outside an operation changes nothing
  a_r7_idle_susp_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !suspended && suspendReq |=> !suspended);
endmodule

bind erase_sched erase_sched_chk i_chk (
  .clk, .rstN, .suspendReq, .abortReq, .preAck, .ersAck, .ackFail,
  .preReq, .ersReq, .busy, .windowOpen, .eraseMask, .suspended, .errFlag
);

// File: tb/test_erase_sched.sv
module test_erase_sched;
  localparam int WIN = 16;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkEraseReq = 0, addBlkReq = 0, chipEraseReq = 0;
  logic suspendReq = 0, resumeReq = 0, abortReq = 0;
  logic [19:0] blkAddr = '0;
  logic preAck = 0, ersAck = 0, ackFail = 0;
  logic preReq, ersReq, busy, windowOpen, suspended, errFlag;
  logic [4:0] opBlk;
  logic [18:0] eraseMask;
  logic bPre, bErs, bBusy, bWin, bSusp, bErr;
  logic [4:0] bOp;
  logic [18:0] bMask;

  int nChk = 0, nBad = 0, cyc = 0;
  bit autoAck = 0, failArm = 0;
  int ackDelay = 1, reqCnt = 0, nErs = 0;
  int ersOrder [32];

  always #2.5 clk = ~clk;

  erase_sched #(.TOP_BOOT(1'b1), .WIN_CYC(WIN), .SUSP_LAT(LAT)) i_erase_sched (
    .clk, .rstN, .blkEraseReq, .addBlkReq, .chipEraseReq, .suspendReq,
    .resumeReq, .abortReq, .blkAddr, .preAck, .ersAck, .ackFail,
    .preReq, .ersReq, .opBlk, .busy, .windowOpen, .eraseMask, .suspended, .errFlag
  );

  erase_sched #(.TOP_BOOT(1'b0), .WIN_CYC(WIN), .SUSP_LAT(LAT)) i_erase_sched_bot (
    .clk, .rstN, .blkEraseReq, .addBlkReq, .chipEraseReq, .suspendReq,
    .resumeReq, .abortReq, .blkAddr, .preAck, .ersAck, .ackFail,
    .preReq(bPre), .ersReq(bErs), .opBlk(bOp), .busy(bBusy), .windowOpen(bWin),
    .eraseMask(bMask), .suspended(bSusp), .errFlag(bErr)
  );

  // array responder for the top-boot instance, acting away from the sampling edge
  always @(negedge clk) begin
    preAck  = 1'b0;
    ersAck  = 1'b0;
    ackFail = 1'b0;
    if (autoAck && (preReq || ersReq)) begin
      reqCnt++;
      if (reqCnt >= ackDelay) begin
        reqCnt = 0;
        if (preReq) preAck = 1'b1;
        else        ersAck = 1'b1;
        ackFail = failArm;
        if (ersReq && !failArm && nErs < 32) begin
          ersOrder[nErs] = int'(opBlk);
          nErs++;
        end
      end
    end else begin
      reqCnt = 0;
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: got running expected finished");
      finishRun();
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && (busy || suspended); i++) tick();
  endtask

  task automatic doAbort();
    abortReq = 1; tick(); abortReq = 0;
  endtask

  // {address, top-boot block, bottom-boot block}
  localparam int NV = 18;
  localparam logic [29:0] VEC [NV] = '{
    {20'h00000, 5'd0,  5'd0},  {20'h03FFF, 5'd0,  5'd0},
    {20'h04000, 5'd0,  5'd1},  {20'h06000, 5'd0,  5'd2},
    {20'h07FFF, 5'd0,  5'd2},  {20'h08000, 5'd0,  5'd3},
    {20'h0FFFF, 5'd0,  5'd3},  {20'h10000, 5'd1,  5'd4},
    {20'h5A5A5, 5'd5,  5'd8},  {20'hEFFFF, 5'd14, 5'd17},
    {20'hF0000, 5'd15, 5'd18}, {20'hF7FFF, 5'd15, 5'd18},
    {20'hF8000, 5'd16, 5'd18}, {20'hF9FFF, 5'd16, 5'd18},
    {20'hFA000, 5'd17, 5'd18}, {20'hFBFFF, 5'd17, 5'd18},
    {20'hFC000, 5'd18, 5'd18}, {20'hFFFFF, 5'd18, 5'd18}
  };

  initial begin
    tick(2);
    // R11: reset state
    chk("R11 busy", busy, 0);
    chk("R11 mask", eraseMask, 0);
    chk("R11 flags", {windowOpen, suspended, errFlag, preReq, ersReq}, 0);
    rstN = 1;
    tick();
    chk("R11 idle after release", {busy, eraseMask}, 0);

    // R1: address to block mapping, both layouts
    for (int v = 0; v < NV; v++) begin
      blkAddr = VEC[v][29:10];
      blkEraseReq = 1; tick(); blkEraseReq = 0;
      chk("R1 top layout", eraseMask, 32'(19'(1) << VEC[v][9:5]));
      chk("R1 bottom layout", bMask, 32'(19'(1) << VEC[v][4:0]));
      chk("R2 window opens", windowOpen, 1);
      doAbort();
    end

    // R2/R3/R12: window restart, merge, ascending order
    autoAck = 0;
    blkAddr = 20'h30000;
    blkEraseReq = 1; tick(); blkEraseReq = 0;
    tick(4);
    blkAddr = 20'h10000;
    addBlkReq = 1; tick(); addBlkReq = 0;
    chk("R2 merged mask", eraseMask, 32'h0000A);
    tick(WIN - 1);
    chk("R2 window restarted", windowOpen, 1);
    tick();
    chk("R2 window closed", windowOpen, 0);
    chk("R3 pre-program first", {preReq, ersReq}, 2'b10);
    chk("R3 lowest block first", opBlk, 1);
    nErs = 0; ackDelay = 2; autoAck = 1;
    waitIdle();
    chk("R3 erase count", nErs, 2);
    chk("R3 order first", ersOrder[0], 1);
    chk("R3 order second", ersOrder[1], 3);
    chk("R12 mask empty", eraseMask, 0);
    chk("R12 not busy", busy, 0);

    // R7: suspend in idle ignored
    suspendReq = 1; tick(); suspendReq = 0;
    chk("R7 idle suspend", {suspended, busy}, 0);

    // R4/R7: chip erase, suspend ignored
    nErs = 0; ackDelay = 1; autoAck = 1;
    chipEraseReq = 1; tick(); chipEraseReq = 0;
    chk("R4 all selected", eraseMask, 32'h7FFFF);
    chk("R4 no window", windowOpen, 0);
    chk("R4 starts now", {preReq, opBlk}, {1'b1, 5'd0});
    suspendReq = 1; tick(); suspendReq = 0;
    tick(LAT + 1);
    chk("R7 chip suspend ignored", suspended, 0);
    waitIdle();
    chk("R4 all erased", nErs, 19);
    chk("R3 chip order", (ersOrder[0] == 0 && ersOrder[9] == 9 && ersOrder[18] == 18), 1);
    chk("R12 chip mask empty", eraseMask, 0);

    // R5/R8: suspend during pre-program, worst-case latency
    autoAck = 0;
    blkAddr = 20'h20000;
    blkEraseReq = 1; tick(); blkEraseReq = 0;
    blkAddr = 20'h50000;
    addBlkReq = 1; tick(); addBlkReq = 0;
    tick(WIN);
    chk("R3 pre on block 2", {preReq, opBlk}, {1'b1, 5'd2});
    suspendReq = 1; tick(); suspendReq = 0;
    tick(LAT - 1);
    chk("R5 still pending", {suspended, preReq}, 2'b01);
    tick();
    chk("R5 suspended in bound", suspended, 1);
    chk("R5 requests dropped", {preReq, ersReq, busy}, 0);
    chk("R5 mask kept", eraseMask, 32'h00024);
    tick(3);
    chk("R5 stays suspended", suspended, 1);
    resumeReq = 1; tick(); resumeReq = 0;
    chk("R8 resumes on lowest", {preReq, opBlk, suspended}, {1'b1, 5'd2, 1'b0});
    nErs = 0; ackDelay = 2; autoAck = 1;
    waitIdle();
    chk("R8 remaining erased", nErs, 2);
    chk("R8 order", {ersOrder[0][4:0], ersOrder[1][4:0]}, {5'd2, 5'd5});
    chk("R12 mask after resume", eraseMask, 0);

    // R6/R9: suspend in window, then abort keeps invalid marker
    autoAck = 0;
    blkAddr = 20'h40000;
    blkEraseReq = 1; tick(); blkEraseReq = 0;
    tick(2);
    suspendReq = 1; tick(); suspendReq = 0;
    chk("R6 window closed", windowOpen, 0);
    chk("R6 suspended", {suspended, preReq}, 2'b10);
    doAbort();
    chk("R9 idle after abort", {busy, suspended}, 0);
    chk("R9 marker kept", eraseMask, 32'h00010);

    // R9: abort during pre-program
    blkAddr = 20'h00000;
    blkEraseReq = 1; tick(); blkEraseReq = 0;
    tick(WIN);
    chk("R9 in pre-program", preReq, 1);
    doAbort();
    chk("R9 abort drops request", {preReq, ersReq, busy}, 0);
    chk("R9 block invalid", eraseMask, 32'h00001);

    // R10: failing ack
    blkAddr = 20'h70000;
    blkEraseReq = 1; tick(); blkEraseReq = 0;
    tick(WIN - 1);
    failArm = 1; ackDelay = 1; autoAck = 1;
    tick(2);
    autoAck = 0; failArm = 0;
    chk("R10 error set", errFlag, 1);
    chk("R10 stopped", {preReq, ersReq, busy}, 0);
    blkAddr = 20'h10000;
    blkEraseReq = 1; tick(); blkEraseReq = 0;
    chk("R10 request ignored", {errFlag, windowOpen, eraseMask}, {1'b1, 1'b0, 19'h00080});
    doAbort();
    chk("R10 cleared by abort", errFlag, 0);

    finishRun();
  end
endmodule